// File: doc/BRIEF.md
# Data-Memory Access Router

This block sits between a processor core's data-memory port and two memories: a 1 KB on-chip SRAM and an external memory reached over a simple request/acknowledge bus. For every access the core presents (address, write data, read/write), the router decides where the access goes. The decision uses the address and a two-bit enable field that comes from the power-management register.

After reset, software has not yet set the enable field. In that state every access goes to the external bus. Once the field holds the value that switches internal mapping on, the lowest 1 KB of the address space is served by the on-chip SRAM. Addresses above that range still fall through to the external bus.

Internal accesses take a single clock. External accesses keep the core waiting until the external side acknowledges.

Top module: `xdata_router`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready`, `busy` and `ext_req` are low. `sram_cs` is low whenever `req` is low.
- R2: Internal mapping is active only when `map_en` equals 2'b01. The values 2'b00, 2'b10 and 2'b11 send every access to the external bus.
- R3: With mapping active, addresses 16'h0000 to 16'h03FF (upper six address bits zero) go to the SRAM. Address 16'h0400 and everything above it go to the external bus.
- R4: An internal access drives `sram_cs`, `sram_we`, `sram_addr` (the low 10 address bits) and `sram_wdata` in the request cycle. `ready` is high in the next cycle, and neither `busy` nor `ext_req` rises.
- R5: An internal read returns the SRAM's read data on `rdata` in the cycle after the request, together with `ready`.
- R6: An external access raises `ext_req` and `busy` in the cycle after the request. `ext_addr`, `ext_we` and `ext_wdata` hold the request's values until a cycle in which `ext_ack` is high. In the following cycle `ext_req` and `busy` are low and `ready` is high.
- R7: An external read returns on `rdata`, with `ready`, the value that `ext_rdata` carried in the acknowledge cycle.
- R8: A request presented while `busy` is high is ignored. It asserts no `sram_cs`, does not change the external address, and produces no extra `ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| map_en | input | 2 | Internal-mapping enable field from the power-management register |
| req | input | 1 | Core access request, one cycle per access |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 16 | Access address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data returned to the core |
| ready | output | 1 | Access complete pulse |
| busy | output | 1 | External access in progress |
| sram_cs | output | 1 | SRAM select |
| sram_we | output | 1 | SRAM write enable |
| sram_addr | output | 10 | SRAM address |
| sram_wdata | output | 8 | SRAM write data |
| sram_rdata | input | 8 | SRAM read data, valid the cycle after select |
| ext_req | output | 1 | External bus request |
| ext_we | output | 1 | External write enable |
| ext_addr | output | 16 | External address |
| ext_wdata | output | 8 | External write data |
| ext_ack | input | 1 | External acknowledge |
| ext_rdata | input | 8 | External read data, valid with acknowledge |

## Verification
The hardest case to reach from the ports is a fresh request that arrives while an external access is still waiting for its acknowledge. A well-behaved core never does this.

The bench therefore injects such a request on purpose. It issues an internal write to address 0 with mapping enabled during a busy cycle, and holds it across an edge. It checks that no SRAM select appears and that the external address stays put. A later read of address 0 then shows whether the write leaked into the SRAM.

Random accesses are concentrated around the 16'h03FF/16'h0400 boundary. They are mixed with all four enable values, and the external responder's acknowledge delay is random.

// File: rtl/xdata_router.sv
module xdata_router #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        map_en,
  input  logic              req,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              ready,
  output logic              busy,
  output logic              sram_cs,
  output logic              sram_we,
  output logic [$clog2(INT_BYTES)-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_wdata,
  input  logic [DATA_W-1:0] sram_rdata,
  output logic              ext_req,
  output logic              ext_we,
  output logic [ADDR_W-1:0] ext_addr,
  output logic [DATA_W-1:0] ext_wdata,
  input  logic              ext_ack,
  input  logic [DATA_W-1:0] ext_rdata
);
  localparam int INT_AW = $clog2(INT_BYTES);
  localparam logic [1:0] MAP_ON = 2'b01;

  logic              hit, accept, from_ext;
  logic [DATA_W-1:0] ext_rd_q;

  assign hit        = (map_en == MAP_ON) && (addr < ADDR_W'(INT_BYTES));
  assign accept     = req && !ext_req;
  assign busy       = ext_req;

  assign sram_cs    = accept && hit;
  assign sram_we    = we;
  assign sram_addr  = addr[INT_AW-1:0];
  assign sram_wdata = wdata;

  assign rdata      = from_ext ? ext_rd_q : sram_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready     <= 1'b0;
      ext_req   <= 1'b0;
      ext_we    <= 1'b0;
      ext_addr  <= '0;
      ext_wdata <= '0;
      ext_rd_q  <= '0;
      from_ext  <= 1'b0;
    end else begin
      ready <= 1'b0;
      if (ext_req) begin
        if (ext_ack) begin
          ext_req  <= 1'b0;
          ready    <= 1'b1;
          from_ext <= 1'b1;
          ext_rd_q <= ext_rdata;
        end
      end else if (accept) begin
        if (hit) begin
          ready    <= 1'b1;
          from_ext <= 1'b0;
        end else begin
          ext_req   <= 1'b1;
          ext_we    <= we;
          ext_addr  <= addr;
          ext_wdata <= wdata;
        end
      end
    end
  end
endmodule

// File: rtl/xdata_router_chk.sv
module xdata_router_chk #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int INT_BYTES = 1024
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        map_en,
  input logic              req,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              busy,
  input logic              sram_cs,
  input logic              ext_req,
  input logic              ext_we,
  input logic [ADDR_W-1:0] ext_addr,
  input logic [DATA_W-1:0] ext_wdata,
  input logic              ext_ack
);
  a_r1_no_select_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req |-> !sram_cs);
  a_r2_map_value: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |-> map_en == 2'b01);
  a_r3_range: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |-> addr < ADDR_W'(INT_BYTES));
  a_r4_int_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    sram_cs |=> ready && !ext_req);
  a_r6_ext_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && !ext_ack |=> ext_req && $stable(ext_addr) && $stable(ext_we) && $stable(ext_wdata));
  a_r6_ext_done: assert property (@(posedge clk) disable iff (!rst_n)
    ext_req && ext_ack |=> !ext_req && !busy && ready);
  a_r8_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sram_cs);
endmodule

bind xdata_router xdata_router_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .INT_BYTES(INT_BYTES)) u_chk (.*);

// File: tb/sim_xdata_router.sv
module sim_xdata_router;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  map_en = 2'b00;
  logic        req = 1'b0, we = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0, rdata, sram_rdata, ext_rdata, sram_wdata, ext_wdata;
  logic        ready, busy, sram_cs, sram_we, ext_req, ext_we, ext_ack;
  logic [9:0]  sram_addr;
  logic [15:0] ext_addr;

  always #10 clk = ~clk;

  xdata_router u0 (.*);

  logic [7:0] sram_m [0:1023];
  logic [7:0] ext_m  [0:65535];
  logic [7:0] exp_int [0:1023];
  logic [7:0] exp_ext [0:65535];
  logic [7:0] sram_q = '0;
  logic [1:0] dly = '0;
  int vectors = 0, errors = 0;

  assign sram_rdata = sram_q;

  always @(posedge clk) begin
    if (sram_cs) begin
      if (sram_we) sram_m[sram_addr] <= sram_wdata;
      sram_q <= sram_m[sram_addr];
    end
  end

  initial ext_ack = 1'b0;
  initial ext_rdata = '0;
  always @(posedge clk) begin
    if (ext_ack) begin
      ext_ack <= 1'b0;
      dly <= 2'($urandom % 4);
    end else if (ext_req) begin
      if (dly == 0) begin
        ext_ack <= 1'b1;
        ext_rdata <= ext_m[ext_addr];
        if (ext_we) ext_m[ext_addr] <= ext_wdata;
      end else dly <= dly - 1'b1;
    end
  end

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic bit exp_hit(input logic [1:0] e, input logic [15:0] a);
    return (e == 2'b01) && (a[15:10] == 6'd0);
  endfunction

  task automatic access(input logic [1:0] e, input logic [15:0] a, input bit w,
                        input logic [7:0] d, input bit poke);
    bit h = exp_hit(e, a);
    logic [7:0] ex = h ? exp_int[a[9:0]] : exp_ext[a];
    int n = 0;
    @(negedge clk);
    map_en = e; addr = a; we = w; wdata = d; req = 1'b1;
    #1;
    chk(sram_cs == h, "R2/R3 route", int'(sram_cs), int'(h));
    if (h) chk(sram_addr == a[9:0], "R4 sram addr", int'(sram_addr), int'(a[9:0]));
    @(negedge clk);
    req = 1'b0;
    if (w) begin
      if (h) exp_int[a[9:0]] = d; else exp_ext[a] = d;
    end
    if (h) begin
      chk(ready && !busy && !ext_req, "R4 ready next cycle", {ready, busy, ext_req}, 3'b100);
      if (!w) chk(rdata == ex, "R5 internal read", int'(rdata), int'(ex));
    end else begin
      chk(ext_req && busy && ext_addr == a, "R6 ext request", int'(ext_addr), int'(a));
      if (poke) begin
        map_en = 2'b01; addr = 16'h0000; we = 1'b1; wdata = ~exp_int[0]; req = 1'b1;
        #1;
        chk(!sram_cs, "R8 no select while busy", int'(sram_cs), 0);
        @(negedge clk);
        req = 1'b0; map_en = e; addr = a; we = w; wdata = d;
        if (!ready) chk(ext_addr == a, "R8 ext addr kept", int'(ext_addr), int'(a));
      end
      while (!ready && n < 50) begin
        chk(ext_req && ext_addr == a && ext_we == w, "R6 hold", int'(ext_addr), int'(a));
        @(negedge clk);
        n++;
      end
      chk(ready && !busy && !ext_req, "R6 completion", {ready, busy, ext_req}, 3'b100);
      if (!w) chk(rdata == ex, "R7 external read", int'(rdata), int'(ex));
      @(negedge clk);
      chk(!ready, "R8 single ready", int'(ready), 0);
    end
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 1024; i++) begin
      sram_m[i] = 8'(i * 7 + 1); exp_int[i] = 8'(i * 7 + 1);
    end
    for (int i = 0; i < 65536; i++) begin
      ext_m[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h3C; exp_ext[i] = ext_m[i];
    end
    repeat (3) @(negedge clk);
    chk(!ready && !busy && !ext_req && !sram_cs, "R1 reset", {ready, busy, ext_req, sram_cs}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!ready && !busy && !ext_req, "R1 after reset", {ready, busy, ext_req}, 0);

    access(2'b00, 16'h0010, 1'b1, 8'h5A, 1'b0);
    access(2'b01, 16'h0010, 1'b0, 8'h00, 1'b0);
    access(2'b00, 16'h0010, 1'b0, 8'h00, 1'b0);
    access(2'b01, 16'h03FF, 1'b1, 8'hC3, 1'b0);
    access(2'b01, 16'h03FF, 1'b0, 8'h00, 1'b0);
    access(2'b01, 16'h0400, 1'b1, 8'h77, 1'b0);
    access(2'b01, 16'h0400, 1'b0, 8'h00, 1'b0);
    access(2'b10, 16'h0020, 1'b0, 8'h00, 1'b0);
    access(2'b11, 16'h0020, 1'b0, 8'h00, 1'b0);
    access(2'b00, 16'h8000, 1'b1, 8'h11, 1'b1);
    access(2'b01, 16'h0000, 1'b0, 8'h00, 1'b0);

    for (int k = 0; k < 600; k++) begin
      logic [1:0] e = ($urandom % 10 < 6) ? 2'b01 : 2'($urandom);
      int sel = $urandom % 4;
      logic [15:0] a = (sel < 2) ? 16'($urandom % 1024)
                     : (sel == 2) ? 16'(16'h03F0 + $urandom % 32) : 16'($urandom);
      access(e, a, 1'($urandom), 8'($urandom), ($urandom % 8) == 0);
    end
    access(2'b01, 16'h0000, 1'b0, 8'h00, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule